// File: doc/BRIEF.md
# EDO DRAM Read Sequencer

This block drives the control strobes and the shared address lines of an extended-data-out DRAM for read accesses. It runs on a clock at twice the bus rate, so every strobe edge falls on a half-bus-cycle boundary. A requester presents a read with a combined row/column address. The sequencer precharges, opens the row, strobes the column, captures the returned word and reports it with a one-cycle done pulse.

While a row is open, a further read flagged as same-row is taken near the end of the CAS precharge. It proceeds as a page-mode access without reopening the row. Four 2-bit wait counts stretch the four phases independently: precharge, row hold, data access and CAS precharge. A write request only inserts a programmable number of idle bus cycles with OE released, so that a following write can turn the data bus around. The write transfer itself is handled elsewhere.

All timing below is counted in cycles of `clk` (half a bus cycle each). Wait inputs are named wRP, wRH, wDA, wCP and idle_cnt (i).

Top module: `edo_read_ctl`

## Requirements
- R1: After reset, and for as long as no request is pending, `ras_n`, `cas_n`, `oe_n` and `we_n` are high and `done` and `taken` are low.
- R2: A read taken from idle keeps `ras_n` high for 1+2·wRP clocks after the `taken` pulse, with the row field `addr[ROW_W+COL_W-1:COL_W]` already on `dram_addr` in the clock before `ras_n` falls.
- R3: `cas_n` falls 2+2·wRH clocks after `ras_n` falls. The column field `addr[COL_W-1:0]` (zero-extended) is on `dram_addr` from one clock before that fall.
- R4: `cas_n` stays low for 1+2·wDA clocks, and `oe_n` is low in exactly the clocks in which `cas_n` is low.
- R5: `rdata` holds the value of `dram_data` at the last clock of the CAS-low phase. `done` is a single-clock pulse in the clock in which `cas_n` returns high.
- R6: A read with `same_row` high that is pending when one clock of CAS precharge remains is taken as a page access. `ras_n` stays low, and consecutive `cas_n` falls are 2+2·wDA+2·wCP clocks apart. When wCP is 0, `taken` and `done` pulse in the same clock.
- R7: For a single off-page read, `ras_n` is low for 5+2·(wRH+wDA+wCP) clocks, and it rises only while `cas_n` is high.
- R8: A write request produces `done` 1+2·i clocks after its `taken` pulse. During that time `ras_n`, `cas_n`, `oe_n` and `we_n` stay high.
- R9: Wait counts changed after `taken` has pulsed do not alter the phase lengths of the access already taken.
- R10: `taken` is a single-clock pulse. A read pending at the page point without `same_row` is not taken there: the row is closed and the read is served with a fresh precharge and the new row address.
- R11: `cas_n` is never low while `ras_n` is high, and it falls only after `ras_n` has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request pending; held until `taken` |
| rd_not_wr | input | 1 | 1 = read access, 0 = write turnaround |
| same_row | input | 1 | Request targets the currently open row |
| addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| w_rp | input | 2 | Precharge wait count |
| w_rh | input | 2 | Row-hold wait count |
| w_da | input | 2 | Data-access wait count |
| w_cp | input | 2 | CAS-precharge wait count |
| idle_cnt | input | 2 | Idle bus cycles before a write |
| dram_data | input | DW | Read data from the memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rdata | output | DW | Captured read word |
| done | output | 1 | Access complete pulse |
| taken | output | 1 | Request accepted pulse |

## Verification
The capture of one read and the acceptance of the next page read can land on the same clock edge. When the CAS-precharge wait is zero, the edge that ends CAS-low both latches `dram_data` and decides whether the pending same-row request is taken. The bench provokes this by holding a second same-row read on the request lines right after the first `taken`, with wCP at 0. It then judges that `done` and `taken` arrive in the same clock, that the first word is the model value of the first column, and that the second CAS fall carries the new column exactly 2+2·wDA clocks later, with no second RAS fall.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // row closed, strobes high
        S_PRE,    // precharge, row address set up
        S_RH,     // RAS low, row address held
        S_CS,     // column address set up
        S_COL,    // CAS and OE low
        S_CP,     // CAS precharge
        S_RCL,    // last RAS-low clock before close
        S_WRW     // idle gap ahead of a write
    } seq_st_e;

    localparam int CNT_W = 3;

    typedef struct packed {
        seq_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic               hit;
        logic               taken;
        logic               done;
        logic               ras_n;
        logic               cas_n;
        logic               oe_n;
        logic               row_sel;
    } seq_t;

    typedef struct packed {
        logic [1:0] rh;
        logic [1:0] da;
        logic [1:0] cp;
    } wait_t;

    // clocks remaining after the first one of a phase: 2*w
    function automatic logic [CNT_W-1:0] extra_clks(input logic [1:0] w);
        return {w, 1'b0};
    endfunction

endpackage

// File: rtl/edo_wait_hold.sv
module edo_wait_hold
    import edo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] w_rh,
    input  logic [1:0] w_da,
    input  logic [1:0] w_cp,
    output wait_t      held
);

    wait_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.rh = w_rh;
            hold_d.da = w_da;
            hold_d.cp = w_cp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign held = hold_q;

endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 9,
    parameter int MA_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic                   row_sel,
    output logic [MA_W-1:0]        dram_addr
);

    localparam int AD_W = ROW_W + COL_W;

    logic [AD_W-1:0] addr_d, addr_q;
    logic [MA_W-1:0] row_ma, col_ma;

    always_comb begin
        addr_d = load ? addr : addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    always_comb begin
        row_ma = '0;
        col_ma = '0;
        row_ma[ROW_W-1:0] = addr_q[AD_W-1:COL_W];
        col_ma[COL_W-1:0] = addr_q[COL_W-1:0];
    end

    assign dram_addr = row_sel ? row_ma : col_ma;

endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          rd_not_wr,
    input  logic          same_row,
    input  logic [1:0]    w_rp,
    input  logic [1:0]    idle_cnt,
    input  wait_t         held,
    input  logic [DW-1:0] dram_data,
    output logic          take,
    output logic          ras_n,
    output logic          cas_n,
    output logic          oe_n,
    output logic          row_sel,
    output logic          done,
    output logic          taken,
    output logic [DW-1:0] rdata
);

    localparam seq_t SEQ_RST = '{st: S_IDLE, cnt: '0, hit: 1'b0, taken: 1'b0,
                                 done: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                 oe_n: 1'b1, row_sel: 1'b1};

    seq_t          seq_d, seq_q;
    logic [DW-1:0] rdat_d, rdat_q;
    logic          last, page_ok;

    assign last    = (seq_q.cnt == '0);
    assign page_ok = req && rd_not_wr && same_row;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.taken = 1'b0;
        rdat_d      = rdat_q;
        case (seq_q.st)
            S_IDLE: begin
                if (req) begin
                    seq_d.taken = 1'b1;
                    if (rd_not_wr) begin
                        seq_d.st  = S_PRE;
                        seq_d.cnt = extra_clks(w_rp);
                    end else begin
                        seq_d.st  = S_WRW;
                        seq_d.cnt = extra_clks(idle_cnt);
                    end
                end
            end
            S_PRE: begin
                if (last) begin
                    seq_d.st  = S_RH;
                    seq_d.cnt = extra_clks(held.rh);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_RH: begin
                if (last) begin
                    seq_d.st  = S_CS;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_CS: begin
                seq_d.st  = S_COL;
                seq_d.cnt = extra_clks(held.da);
            end
            S_COL: begin
                if (last) begin
                    seq_d.st   = S_CP;
                    seq_d.cnt  = extra_clks(held.cp);
                    seq_d.done = 1'b1;
                    rdat_d     = dram_data;
                    if (held.cp == 2'd0 && page_ok) begin
                        seq_d.taken = 1'b1;
                        seq_d.hit   = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_CP: begin
                if (last) begin
                    if (seq_q.hit) begin
                        seq_d.st  = S_COL;
                        seq_d.cnt = extra_clks(held.da);
                        seq_d.hit = 1'b0;
                    end else begin
                        seq_d.st = S_RCL;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                    if (seq_q.cnt == 3'd1 && !seq_q.hit && page_ok) begin
                        seq_d.taken = 1'b1;
                        seq_d.hit   = 1'b1;
                    end
                end
            end
            S_RCL: begin
                seq_d.st  = S_IDLE;
                seq_d.cnt = '0;
            end
            S_WRW: begin
                if (last) begin
                    seq_d.st   = S_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
        // strobes follow the state being entered, so they leave a register
        seq_d.ras_n   = !(seq_d.st inside {S_RH, S_CS, S_COL, S_CP, S_RCL});
        seq_d.cas_n   = (seq_d.st != S_COL);
        seq_d.oe_n    = (seq_d.st != S_COL);
        seq_d.row_sel = (seq_d.st inside {S_IDLE, S_PRE, S_RH, S_WRW});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SEQ_RST;
            rdat_q <= '0;
        end else begin
            seq_q  <= seq_d;
            rdat_q <= rdat_d;
        end
    end

    assign take    = seq_d.taken;
    assign ras_n   = seq_q.ras_n;
    assign cas_n   = seq_q.cas_n;
    assign oe_n    = seq_q.oe_n;
    assign row_sel = seq_q.row_sel;
    assign done    = seq_q.done;
    assign taken   = seq_q.taken;
    assign rdata   = rdat_q;

endmodule

// File: rtl/edo_read_ctl.sv
module edo_read_ctl
    import edo_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 9,
    parameter int DW    = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req,
    input  logic                                   rd_not_wr,
    input  logic                                   same_row,
    input  logic [ROW_W+COL_W-1:0]                 addr,
    input  logic [1:0]                             w_rp,
    input  logic [1:0]                             w_rh,
    input  logic [1:0]                             w_da,
    input  logic [1:0]                             w_cp,
    input  logic [1:0]                             idle_cnt,
    input  logic [DW-1:0]                          dram_data,
    output logic                                   ras_n,
    output logic                                   cas_n,
    output logic                                   oe_n,
    output logic                                   we_n,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
    output logic [DW-1:0]                          rdata,
    output logic                                   done,
    output logic                                   taken
);

    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic  take, row_sel;
    wait_t held;

    edo_wait_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .w_rh  (w_rh),
        .w_da  (w_da),
        .w_cp  (w_cp),
        .held  (held)
    );

    edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_amux (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .addr      (addr),
        .row_sel   (row_sel),
        .dram_addr (dram_addr)
    );

    edo_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .rd_not_wr (rd_not_wr),
        .same_row  (same_row),
        .w_rp      (w_rp),
        .idle_cnt  (idle_cnt),
        .held      (held),
        .dram_data (dram_data),
        .take      (take),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .oe_n      (oe_n),
        .row_sel   (row_sel),
        .done      (done),
        .taken     (taken),
        .rdata     (rdata)
    );

    // this sequencer only reads; the write strobe is parked inactive
    assign we_n = 1'b1;

endmodule

// File: rtl/edo_read_ctl_chk.sv
module edo_read_ctl_chk #(
    parameter int MA_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            done,
    input logic            taken,
    input logic [MA_W-1:0] dram_addr
);

    // R11
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R11
    cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    // R2
    row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(dram_addr));

    // R3
    col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(dram_addr));

    // R5
    done_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cas_n);

    // R7
    ras_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n && $past(cas_n)));

    // R10
    taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

    // R8
    we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> we_n);

endmodule

bind edo_read_ctl edo_read_ctl_chk #(.MA_W(MA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .done      (done),
    .taken     (taken),
    .dram_addr (dram_addr)
);

// File: tb/edo_read_ctl_tb_top.sv
module edo_read_ctl_tb_top;

    localparam int ROW_W = 10;
    localparam int COL_W = 9;
    localparam int DW    = 16;
    localparam int MA_W  = 10;

    // {wRP, wRH, wDA, wCP, row, col}
    localparam logic [26:0] VEC [6] = '{
        {2'd0, 2'd0, 2'd0, 2'd0, 10'h155, 9'h0AA},
        {2'd1, 2'd0, 2'd0, 2'd0, 10'h2A3, 9'h011},
        {2'd0, 2'd2, 2'd1, 2'd0, 10'h001, 9'h1FF},
        {2'd3, 2'd1, 2'd3, 2'd2, 10'h3FF, 9'h100},
        {2'd2, 2'd3, 2'd0, 2'd3, 10'h080, 9'h000},
        {2'd1, 2'd1, 2'd2, 2'd1, 10'h12C, 9'h0C3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                   req = 1'b0, rd_not_wr = 1'b1, same_row = 1'b0;
    logic [ROW_W+COL_W-1:0] addr = '0;
    logic [1:0]             w_rp = '0, w_rh = '0, w_da = '0, w_cp = '0, idle_cnt = '0;
    logic [DW-1:0]          dram_data;
    logic                   ras_n, cas_n, oe_n, we_n, done, taken;
    logic [MA_W-1:0]        dram_addr;
    logic [DW-1:0]          rdata;

    edo_read_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_not_wr(rd_not_wr),
        .same_row(same_row), .addr(addr), .w_rp(w_rp), .w_rh(w_rh),
        .w_da(w_da), .w_cp(w_cp), .idle_cnt(idle_cnt), .dram_data(dram_data),
        .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n),
        .dram_addr(dram_addr), .rdata(rdata), .done(done), .taken(taken)
    );

    function automatic logic [DW-1:0] mem_word(input logic [MA_W-1:0] a);
        return DW'(a) * DW'(3) + DW'(16'h1234);
    endfunction

    assign dram_data = cas_n ? '0 : mem_word(dram_addr);

    int errs = 0, checks = 0;
    int tk = 0;
    always @(posedge clk) tk <= tk + 1;

    // event monitor, sampled mid-cycle
    logic ras_p = 1'b1, cas_p = 1'b1, done_p = 1'b0;
    int n_take = 0, n_rf = 0, n_rr = 0, n_cf = 0, n_done = 0;
    int t_take = 0, t_rf = 0, t_rr = 0, t_cf = 0, t_cf_prev = 0, t_cr = 0, t_done = 0;
    int oe_bad = 0, we_bad = 0, dbl_done = 0;
    logic [MA_W-1:0] row_rf = '0, col_cf = '0;
    logic [DW-1:0]   rd_log [4];

    always @(negedge clk) begin
        if (rst_n) begin
            if (taken) begin n_take++; t_take = tk; end
            if (ras_p && !ras_n) begin n_rf++; t_rf = tk; row_rf = dram_addr; end
            if (!ras_p && ras_n) begin n_rr++; t_rr = tk; end
            if (cas_p && !cas_n) begin n_cf++; t_cf_prev = t_cf; t_cf = tk; col_cf = dram_addr; end
            if (!cas_p && cas_n) t_cr = tk;
            if (done) begin
                rd_log[n_done % 4] = rdata;
                n_done++;
                t_done = tk;
                if (done_p) dbl_done++;
            end
            if (oe_n !== cas_n) oe_bad++;
            if (we_n !== 1'b1) we_bad++;
        end
        ras_p  = ras_n;
        cas_p  = cas_n;
        done_p = done;
    end

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_waits(input logic [7:0] w);
        {w_rp, w_rh, w_da, w_cp} = w;
    endtask

    task automatic run_read(input logic [7:0] w, input logic [ROW_W-1:0] r,
                            input logic [COL_W-1:0] c, input bit mutate);
        int take0 = n_take, rf0 = n_rf, rr0 = n_rr, d0 = n_done, oe0 = oe_bad;
        int rp = int'(w[7:6]), rh = int'(w[5:4]), da = int'(w[3:2]), cp = int'(w[1:0]);
        set_waits(w);
        addr = {r, c}; rd_not_wr = 1'b1; same_row = 1'b0; req = 1'b1;
        while (n_take < take0 + 1) tick();
        req = 1'b0;
        if (mutate) set_waits(8'hFF);
        while (n_rr < rr0 + 1) tick();
        chk_eq(mutate ? "R9 precharge" : "R2 precharge", t_rf - t_take, 1 + 2*rp);
        chk_eq("R2 row on bus", row_rf, MA_W'(r));
        chk_eq(mutate ? "R9 ras-to-cas" : "R3 ras-to-cas", t_cf - t_rf, 2 + 2*rh);
        chk_eq("R3 column on bus", col_cf, MA_W'(c));
        chk_eq(mutate ? "R9 cas width" : "R4 cas width", t_cr - t_cf, 1 + 2*da);
        chk_eq("R4 oe follows cas", oe_bad - oe0, 0);
        chk_eq("R5 read word", rd_log[d0 % 4], mem_word(MA_W'(c)));
        chk_eq("R5 done at cas rise", t_done, t_cr);
        chk_eq("R5 done count", n_done - d0, 1);
        chk_eq(mutate ? "R9 ras width" : "R7 ras width", t_rr - t_rf, 5 + 2*(rh + da + cp));
        chk_eq("R11 single row open", n_rf - rf0, 1);
    endtask

    task automatic run_page(input logic [7:0] w, input logic [ROW_W-1:0] r,
                            input logic [COL_W-1:0] c1, input logic [COL_W-1:0] c2);
        int take0 = n_take, rf0 = n_rf, rr0 = n_rr, d0 = n_done;
        int da = int'(w[3:2]), cp = int'(w[1:0]);
        set_waits(w);
        addr = {r, c1}; rd_not_wr = 1'b1; same_row = 1'b0; req = 1'b1;
        while (n_take < take0 + 1) tick();
        addr = {r, c2}; same_row = 1'b1;
        while (n_take < take0 + 2) tick();
        req = 1'b0; same_row = 1'b0;
        if (cp == 0) chk_eq("R6 taken with done", t_take, t_done);
        while (n_rr < rr0 + 1) tick();
        chk_eq("R6 one RAS fall", n_rf - rf0, 1);
        chk_eq("R6 page period", t_cf - t_cf_prev, 2 + 2*da + 2*cp);
        chk_eq("R6 second column", col_cf, MA_W'(c2));
        chk_eq("R6 first word", rd_log[d0 % 4], mem_word(MA_W'(c1)));
        chk_eq("R6 second word", rd_log[(d0 + 1) % 4], mem_word(MA_W'(c2)));
        chk_eq("R6 done pulses", n_done - d0, 2);
    endtask

    task automatic run_close(input logic [7:0] w, input logic [ROW_W-1:0] r1,
                             input logic [ROW_W-1:0] r2, input logic [COL_W-1:0] c2);
        int take0 = n_take, rf0 = n_rf, rr0 = n_rr, d0 = n_done;
        int rp = int'(w[7:6]);
        set_waits(w);
        addr = {r1, 9'h055}; rd_not_wr = 1'b1; same_row = 1'b0; req = 1'b1;
        while (n_take < take0 + 1) tick();
        addr = {r2, c2};
        while (n_take < take0 + 2) tick();
        req = 1'b0;
        while (n_rr < rr0 + 2) tick();
        chk_eq("R10 row reopened", n_rf - rf0, 2);
        chk_eq("R10 new row on bus", row_rf, MA_W'(r2));
        chk_eq("R10 fresh precharge", t_rf - t_take, 1 + 2*rp);
        chk_eq("R10 second word", rd_log[(d0 + 1) % 4], mem_word(MA_W'(c2)));
    endtask

    task automatic run_write(input logic [1:0] i);
        int take0 = n_take, rf0 = n_rf, cf0 = n_cf, d0 = n_done, oe0 = oe_bad;
        idle_cnt = i; rd_not_wr = 1'b0; req = 1'b1;
        while (n_take < take0 + 1) tick();
        req = 1'b0; rd_not_wr = 1'b1;
        while (n_done < d0 + 1) tick();
        chk_eq("R8 idle gap", t_done - t_take, 1 + 2*int'(i));
        chk_eq("R8 no RAS", n_rf - rf0, 0);
        chk_eq("R8 no CAS", n_cf - cf0, 0);
        chk_eq("R8 OE high", oe_bad - oe0, 0);
        chk_eq("R8 OE level", oe_n, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1: idle state after reset
        chk_eq("R1 ras_n", ras_n, 1);
        chk_eq("R1 cas_n", cas_n, 1);
        chk_eq("R1 oe_n", oe_n, 1);
        chk_eq("R1 we_n", we_n, 1);
        chk_eq("R1 done", done, 0);
        chk_eq("R1 taken", taken, 0);
        repeat (12) tick();
        chk_eq("R1 idle without request", n_rf + n_take, 0);

        for (int k = 0; k < 6; k++) begin
            run_read(VEC[k][26:19], VEC[k][18:9], VEC[k][8:0], 1'b0);
            repeat (2) tick();
        end

        // R9: waits raised right after acceptance
        run_read(8'h00, 10'h0F0, 9'h033, 1'b1);
        repeat (2) tick();

        // R6: capture and page acceptance on the same edge
        run_page(8'h00, 10'h111, 9'h010, 9'h011);
        repeat (2) tick();
        run_page({2'd1, 2'd0, 2'd1, 2'd2}, 10'h222, 9'h1F0, 9'h00F);
        repeat (2) tick();
        run_page({2'd0, 2'd1, 2'd2, 2'd0}, 10'h3A5, 9'h101, 9'h102);
        repeat (2) tick();

        // R10: pending read at the page point without same_row
        run_close({2'd2, 2'd0, 2'd0, 2'd1}, 10'h044, 10'h300, 9'h0EE);
        repeat (2) tick();

        // R8: write turnaround gaps
        run_write(2'd0);
        repeat (2) tick();
        run_write(2'd3);
        repeat (2) tick();

        chk_eq("R10 taken single pulse / R5 done single", dbl_done, 0);
        chk_eq("R8 we_n never low", we_bad, 0);
        chk_eq("R1 idle after traffic", ras_n & cas_n & oe_n, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule